// File: doc/BRIEF.md
# Timestamp Lease Library Controller

This controller sits at the home end of one address-range slice in a coherence scheme built on leases. It does not keep a sharer list. A load request receives the line data together with an expiry time. The reader may keep its copy while the shared global time is not past that expiry. For each line the controller records one thing: the latest expiry it has handed out. It never sends invalidations. Coherence holds because a store waits until that recorded expiry lies in the past.

Stores enter an in-order queue of fixed depth. The queue head commits to backing memory once its line has no live lease. An acknowledgement carrying the line address follows one cycle later. The lease length is a configurable fixed period, added to the current time. No grant ever reaches past the last value before the time counter wraps.

Top module: `lease_lib_ctrl`

## Requirements
- R1: A load accepted at a clock edge raises `rsp_valid` for exactly the following cycle. `rsp_data` then holds the backing-memory word of that line as it was before the edge.
- R2: Suppose a line has no live lease (a lease is live while its recorded expiry is not less than `now`) and no queued store. A load then gets expiry `now + lease_period`, and the line records that value.
- R3: Suppose a line already has a live lease and no queued store. A load gets `now + lease_period`, and the recorded expiry becomes the larger of the old and new values.
- R4: Suppose a line has a live lease and at least one queued store. A load gets exactly the recorded expiry, and the record stays unchanged.
- R5: Suppose a line has queued stores but no live lease. A load gets expiry equal to `now` at acceptance, which has already lapsed when the response arrives, and nothing is recorded.
- R6: Only the oldest queued store may commit. It commits, with `mem_wr_en` high in that cycle, only when its line has no live lease. Stores commit in arrival order.
- R7: `ack_valid` is high for one cycle, with `ack_addr` set to the line, in the cycle after each commit.
- R8: `req_ready` is low for a store while the queue holds its full depth of entries. Loads are accepted at any time.
- R9: No granted expiry exceeds all-ones minus one. When `now` is all ones, every lease is dropped, and a load in that cycle gets expiry `now` and records nothing.
- R10: During reset `rsp_valid`, `ack_valid` and `mem_wr_en` are low. After reset no line holds a lease.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| now | input | TS_W | Shared global time, one step per cycle |
| lease_period | input | TS_W | Lease length added to `now` |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Line index |
| req_data | input | DATA_W | Store data |
| rsp_valid | output | 1 | Load response present |
| rsp_data | output | DATA_W | Line data |
| rsp_expiry | output | TS_W | Lease expiry for the returned copy |
| ack_valid | output | 1 | Store acknowledgement |
| ack_addr | output | ADDR_W | Line of the acknowledged store |
| mem_rd_addr | output | ADDR_W | Backing-memory read index (combinational read) |
| mem_rd_data | input | DATA_W | Backing-memory read word |
| mem_wr_en | output | 1 | Commit write strobe |
| mem_wr_addr | output | ADDR_W | Commit line |
| mem_wr_data | output | DATA_W | Commit data |

## Verification
`req_ready` and the commit strobe with its address and data are combinational, so they are due in the same cycle as the inputs. The bench compares them shortly after driving each cycle's inputs. The load response and the store acknowledgement sit one register away, so they are due one cycle after the accepting edge or commit edge. The bench compares them at the falling edge that follows. A behavioural reference advances once per rising edge with the same inputs and supplies the expected values at both sampling points.

// File: rtl/lease_pkg.sv
`timescale 1ns/1ps
package lease_pkg;
  typedef enum logic [1:0] {
    GK_FRESH   = 2'd0,
    GK_EXTEND  = 2'd1,
    GK_HOLD    = 2'd2,
    GK_NOCACHE = 2'd3
  } grant_kind_e;
endpackage

// File: rtl/lease_wq.sv
`timescale 1ns/1ps
module lease_wq #(
  parameter int DEPTH = 4,
  parameter int AW    = 4,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          full,
  output logic          head_valid,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_hit
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d, wr_ptr_q, wr_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DEPTH-1:0] hit;

  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign head_valid = (cnt_q != '0);
  assign head_addr  = addr_q[rd_ptr_q];
  assign head_data  = data_q[rd_ptr_q];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [PTR_W-1:0] offs;
    assign offs   = PTR_W'(i) - rd_ptr_q;
    assign hit[i] = ({1'b0, offs} < cnt_q) && (addr_q[i] == probe_addr);
  end
  assign probe_hit = |hit;

  always_comb begin
    rd_ptr_d = rd_ptr_q;
    wr_ptr_d = wr_ptr_q;
    cnt_d    = cnt_q;
    if (push) wr_ptr_d = wr_ptr_q + PTR_W'(1);
    if (pop)  rd_ptr_d = rd_ptr_q + PTR_W'(1);
    if (push && !pop) cnt_d = cnt_q + CNT_W'(1);
    else if (pop && !push) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      rd_ptr_q <= rd_ptr_d;
      wr_ptr_q <= wr_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr_q] <= push_addr;
      data_q[wr_ptr_q] <= push_data;
    end
  end

  // R8: the request side must never push into a full queue
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R6: a commit only pops an occupied queue
  assert_pop_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_valid);
endmodule

// File: rtl/lease_table.sv
`timescale 1ns/1ps
module lease_table #(
  parameter int AW   = 4,
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] now,
  input  logic [AW-1:0]   rd_addr,
  output logic [TS_W-1:0] rd_tmax,
  output logic            rd_live,
  input  logic [AW-1:0]   chk_addr,
  output logic            chk_live,
  input  logic            grant_en,
  input  logic [TS_W-1:0] grant_tmax
);
  localparam int LINES = 1 << AW;

  logic [TS_W-1:0]  tmax_q [LINES];
  logic [LINES-1:0] live_q, live_d;
  logic             wrap_now;

  assign wrap_now = &now;
  assign rd_tmax  = tmax_q[rd_addr];
  assign rd_live  = live_q[rd_addr] && !(tmax_q[rd_addr] < now);
  assign chk_live = live_q[chk_addr] && !(tmax_q[chk_addr] < now);

  always_comb begin
    live_d = live_q;
    if (grant_en) live_d[rd_addr] = 1'b1;
    if (wrap_now) live_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= '0;
    else        live_q <= live_d;
  end

  always_ff @(posedge clk) begin
    if (grant_en) tmax_q[rd_addr] <= grant_tmax;
  end

  // R3: a renewed live lease never lowers the recorded expiry
  assert_tmax_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_en && rd_live) |-> (grant_tmax >= rd_tmax));
  // R9: nothing is recorded in the wrap cycle
  assert_no_grant_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    grant_en |-> !wrap_now);
endmodule

// File: rtl/lease_lib_ctrl.sv
`timescale 1ns/1ps
module lease_lib_ctrl
  import lease_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int TS_W     = 16,
  parameter int WQ_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   now,
  input  logic [TS_W-1:0]   lease_period,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [TS_W-1:0]   rsp_expiry,
  output logic              ack_valid,
  output logic [ADDR_W-1:0] ack_addr,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  localparam logic [TS_W-1:0] TS_ALL = '1;
  localparam logic [TS_W-1:0] TS_LIM = TS_ALL - TS_W'(1);

  logic              wq_full, wq_head_v, wq_pending, wq_push;
  logic [ADDR_W-1:0] wq_head_a;
  logic [DATA_W-1:0] wq_head_d;
  logic [TS_W-1:0]   tbl_tmax, grant_tmax, t_heur, expiry_d;
  logic              tbl_live, head_live, grant_en, ld_acc, commit;
  logic [TS_W:0]     sum_w;
  grant_kind_e       kind;

  logic              rsp_valid_q, ack_valid_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic [TS_W-1:0]   rsp_expiry_q;
  logic [ADDR_W-1:0] ack_addr_q;

  assign req_ready = !(req_write && wq_full);
  assign ld_acc    = req_valid && req_ready && !req_write;
  assign wq_push   = req_valid && req_ready && req_write;
  assign mem_rd_addr = req_addr;

  assign commit      = wq_head_v && !head_live;
  assign mem_wr_en   = commit;
  assign mem_wr_addr = wq_head_a;
  assign mem_wr_data = wq_head_d;

  lease_wq #(.DEPTH(WQ_DEPTH), .AW(ADDR_W), .DW(DATA_W)) wq_i (
    .clk(clk), .rst_n(rst_n),
    .push(wq_push), .push_addr(req_addr), .push_data(req_data),
    .pop(commit), .full(wq_full),
    .head_valid(wq_head_v), .head_addr(wq_head_a), .head_data(wq_head_d),
    .probe_addr(req_addr), .probe_hit(wq_pending)
  );

  lease_table #(.AW(ADDR_W), .TS_W(TS_W)) tbl_i (
    .clk(clk), .rst_n(rst_n), .now(now),
    .rd_addr(req_addr), .rd_tmax(tbl_tmax), .rd_live(tbl_live),
    .chk_addr(wq_head_a), .chk_live(head_live),
    .grant_en(grant_en), .grant_tmax(grant_tmax)
  );

  // lease heuristic, saturated below the wrap point
  always_comb begin
    sum_w  = {1'b0, now} + {1'b0, lease_period};
    t_heur = (sum_w >= {1'b0, TS_LIM}) ? TS_LIM : sum_w[TS_W-1:0];
  end

  always_comb begin
    if (&now)             kind = GK_NOCACHE;
    else if (wq_pending)  kind = tbl_live ? GK_HOLD : GK_NOCACHE;
    else if (tbl_live)    kind = GK_EXTEND;
    else                  kind = GK_FRESH;
    unique case (kind)
      GK_FRESH:   begin expiry_d = t_heur;   grant_tmax = t_heur; end
      GK_EXTEND:  begin expiry_d = t_heur;
                        grant_tmax = (t_heur > tbl_tmax) ? t_heur : tbl_tmax; end
      GK_HOLD:    begin expiry_d = tbl_tmax; grant_tmax = tbl_tmax; end
      default:    begin expiry_d = now;      grant_tmax = tbl_tmax; end
    endcase
    grant_en = ld_acc && (kind == GK_FRESH || kind == GK_EXTEND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      ack_valid_q <= 1'b0;
    end else begin
      rsp_valid_q <= ld_acc;
      ack_valid_q <= commit;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_acc) begin
      rsp_data_q   <= mem_rd_data;
      rsp_expiry_q <= expiry_d;
    end
    if (commit) ack_addr_q <= wq_head_a;
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_data   = rsp_data_q;
  assign rsp_expiry = rsp_expiry_q;
  assign ack_valid  = ack_valid_q;
  assign ack_addr   = ack_addr_q;

  // R1: every accepted load is answered on the next cycle
  assert_load_answered_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_acc |=> rsp_valid);
  // R7: every commit is acknowledged on the next cycle
  assert_commit_acked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (ack_valid && ack_addr == $past(mem_wr_addr)));
  // R7: no acknowledgement without a preceding commit
  assert_no_spurious_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_en |=> !ack_valid);
endmodule

// File: tb/lease_lib_ctrl_tb_top.sv
`timescale 1ns/1ps
module lease_lib_ctrl_tb_top;
  localparam int AW = 4, DW = 32, TW = 16, DEP = 4, LINES = 16;
  localparam int TMAXV = 65535;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_write, rsp_valid, ack_valid, mem_wr_en;
  logic [TW-1:0] now, lease_period, rsp_expiry;
  logic [AW-1:0] req_addr, ack_addr, mem_rd_addr, mem_wr_addr;
  logic [DW-1:0] req_data, rsp_data, mem_rd_data, mem_wr_data;
  logic [DW-1:0] mem_arr [LINES];

  lease_lib_ctrl #(.ADDR_W(AW), .DATA_W(DW), .TS_W(TW), .WQ_DEPTH(DEP)) dut_i (
    .clk(clk), .rst_n(rst_n), .now(now), .lease_period(lease_period),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_expiry(rsp_expiry),
    .ack_valid(ack_valid), .ack_addr(ack_addr),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
  );

  assign mem_rd_data = mem_arr[mem_rd_addr];
  always @(posedge clk) if (mem_wr_en) mem_arr[mem_wr_addr] <= mem_wr_data;

  // behavioural reference
  typedef struct { int a; logic [DW-1:0] d; } wr_t;
  wr_t         mq[$];
  int          m_tmax [LINES];
  bit          m_live [LINES];
  logic [DW-1:0] m_mem [LINES];
  bit          e_rsp_v, e_ack_v;
  logic [DW-1:0] e_rsp_d;
  int          e_rsp_x, e_ack_a;
  string       e_tag;
  int vectors = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_le(int a, int t);
    return m_live[a] && (m_tmax[a] >= t);
  endfunction

  task automatic step();
    int t, n_exp, a;
    bit exp_ready, acc, commit, pend;
    #1;
    t = int'(now);
    exp_ready = !(req_write && mq.size() == DEP);
    chk("R8 req_ready", req_ready, exp_ready);
    acc = req_valid && exp_ready;
    commit = (mq.size() > 0) && !m_le(mq[0].a, t);
    chk("R6 mem_wr_en", mem_wr_en, commit);
    if (commit) begin
      chk("R6 mem_wr_addr", mem_wr_addr, mq[0].a);
      chk("R6 mem_wr_data", mem_wr_data, mq[0].d);
    end
    e_rsp_v = 0;
    e_ack_v = commit;
    if (commit) e_ack_a = mq[0].a;
    if (acc && !req_write) begin
      a = int'(req_addr);
      e_rsp_v = 1;
      e_rsp_d = m_mem[a];
      pend = 0;
      foreach (mq[i]) if (mq[i].a == a) pend = 1;
      n_exp = t + int'(lease_period);
      if (n_exp > TMAXV - 1) n_exp = TMAXV - 1;
      if (t == TMAXV) begin e_rsp_x = t; e_tag = "R9"; end
      else if (pend) begin
        if (m_le(a, t)) begin e_rsp_x = m_tmax[a]; e_tag = "R4"; end
        else begin e_rsp_x = t; e_tag = "R5"; end
      end else begin
        e_tag = (n_exp == TMAXV - 1) ? "R9" : (m_le(a, t) ? "R3" : "R2");
        e_rsp_x = n_exp;
        if (m_le(a, t)) begin if (n_exp > m_tmax[a]) m_tmax[a] = n_exp; end
        else m_tmax[a] = n_exp;
        m_live[a] = 1;
      end
    end
    if (commit) begin
      m_mem[mq[0].a] = mq[0].d;
      void'(mq.pop_front());
    end
    if (acc && req_write) mq.push_back('{int'(req_addr), req_data});
    if (t == TMAXV) foreach (m_live[i]) m_live[i] = 0;
    @(posedge clk);
    @(negedge clk);
    now = now + 1'b1;
    chk("R1 rsp_valid", rsp_valid, e_rsp_v);
    if (e_rsp_v) begin
      chk("R1 rsp_data", rsp_data, e_rsp_d);
      chk({e_tag, " rsp_expiry"}, rsp_expiry, e_rsp_x);
    end
    chk("R7 ack_valid", ack_valid, e_ack_v);
    if (e_ack_v) chk("R7 ack_addr", ack_addr, e_ack_a);
  endtask

  task automatic load(int a);
    req_valid = 1; req_write = 0; req_addr = AW'(a);
    step();
    req_valid = 0;
  endtask

  task automatic store(int a, logic [DW-1:0] d);
    req_valid = 1; req_write = 1; req_addr = AW'(a); req_data = d;
    step();
    req_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_data = '0;
    now = 16'd100; lease_period = 16'd20;
    for (int i = 0; i < LINES; i++) begin
      mem_arr[i] = 32'h1111 * i + 5;
      m_mem[i] = mem_arr[i];
      m_live[i] = 0; m_tmax[i] = 0;
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R10 rsp_valid", rsp_valid, 0);
      chk("R10 ack_valid", ack_valid, 0);
      chk("R10 mem_wr_en", mem_wr_en, 0);
    end
    rst_n = 1;
    // R10: lease-free after reset: a store commits at once
    store(1, 32'h0000_00F1);
    idle(2);
    load(3);                       // R2 fresh lease
    lease_period = 16'd5;
    load(3);                       // R3 shorter lease, record kept
    store(3, 32'hAAAA_0003);       // waits for lease on line 3
    load(3);                       // R4 hold at recorded expiry
    store(5, 32'hBBBB_0005);       // queued behind line 3 (R6 order)
    load(5);                       // R5 pending, no lease
    idle(25);
    load(3);                       // R1 committed data visible
    lease_period = 16'd30;
    load(9);
    for (int i = 0; i < 5; i++) store(9, 32'hC000_0000 + i);   // R8 fifth refused
    load(2);                       // R8 loads still taken while full
    idle(40);
    load(9);
    // R9: wrap handling
    now = 16'hFFF0; lease_period = 16'd100;
    load(4);
    store(4, 32'hDDDD_0004);
    while (now != 16'hFFFF) step();
    load(4);
    idle(3);
    load(4);
    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule